// File: doc/BRIEF.md
# Level-Triggered Capture Window Controller

This block holds a set of independent capture windows, one for each trace stream: program counter, timing, read address, read data, write address, write data and program-counter tag. Each window has a level-sensitive open request and a level-sensitive close request. It drives one enable line that tells the capture path whether to take a sample in the current cycle.

The window is inclusive at both ends. The enable rises in the same cycle as the open request and falls only after the cycle that carries the close request. A window that is already closed and sees both requests in one cycle gives a single enabled cycle. An open request in the cycle after a close request keeps the enable high without a gap. A synchronous reset closes every window at once.

Top module: `capture_window_ctl`

## Requirements
- R1: While reset is high, every window is closed at the next edge. After reset, with no requests, every bit of `cap_en` is 0.
- R2: `cap_en[i]` is high in any cycle in which `win_start[i]` is high, with no cycle of delay.
- R3: Once a window opens, `cap_en[i]` stays high in every following cycle until a cycle in which `win_stop[i]` is high, and that cycle is included.
- R4: In the cycle after a cycle with `win_stop[i]` high, `cap_en[i]` is high only if `win_start[i]` is high in that cycle.
- R5: If `win_start[i]` and `win_stop[i]` are both high while the window is closed, `cap_en[i]` is high for exactly that cycle.
- R6: If `win_start[i]` and `win_stop[i]` are both high while the window is open, `cap_en[i]` is high in that cycle and the window is closed after it.
- R7: `win_stop[i]` alone on a closed window leaves `cap_en[i]` low.
- R8: Each channel's enable depends only on that channel's own requests. Bit i of each port belongs to channel i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; closes all windows |
| win_start | input | NUM_CH | Per-channel level open request |
| win_stop | input | NUM_CH | Per-channel level close request |
| cap_en | output | NUM_CH | Per-channel capture enable for the current cycle |

## Verification
Every channel gets an exhaustive sweep of all two-cycle and three-cycle sequences of the four start/stop combinations, started from both the open and the closed state. This separates the same-cycle open, the inclusive close, the single-cycle window and the gapless restart from an off-by-one-cycle implementation. A long pseudo-random run drives different patterns on all channels at once against a per-channel reference model. That run exposes any crosstalk between channels or wrong bit mapping. Reset is applied in the middle of open windows to confirm that all windows close together.

// File: rtl/capture_window_ctl.sv
module capture_window_ctl #(
  parameter int NUM_CH = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] win_start,
  input  logic [NUM_CH-1:0] win_stop,
  output logic [NUM_CH-1:0] cap_en
);

  logic [NUM_CH-1:0] open_q;

  assign cap_en = open_q | win_start;

  always_ff @(posedge clk) begin
    if (rst) open_q <= '0;
    else     open_q <= cap_en & ~win_stop;
  end

  // R1
  reset_closes_chk: assert property (@(posedge clk) rst |=> (open_q == '0));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    // R2
    start_same_cycle_chk: assert property (@(posedge clk) disable iff (rst)
      win_start[i] |-> cap_en[i]);
    // R3
    hold_until_stop_chk: assert property (@(posedge clk) disable iff (rst)
      (cap_en[i] && !win_stop[i]) |=> cap_en[i]);
    // R4
    after_stop_chk: assert property (@(posedge clk) disable iff (rst)
      win_stop[i] |=> (cap_en[i] == win_start[i]));
    // R7
    lone_stop_chk: assert property (@(posedge clk) disable iff (rst)
      (win_stop[i] && !win_start[i] && !open_q[i]) |-> !cap_en[i]);
  end

endmodule

// File: tb/capture_window_ctl_bench.sv
module capture_window_ctl_bench;
  localparam int NUM_CH = 7;

  logic clk = 1'b0;
  logic rst;
  logic [NUM_CH-1:0] win_start, win_stop, cap_en;
  logic [NUM_CH-1:0] model_open;
  int vectors = 0, errors = 0;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always #2.5 clk = ~clk;

  capture_window_ctl #(.NUM_CH(NUM_CH)) u_capture_window_ctl (
    .clk(clk), .rst(rst), .win_start(win_start), .win_stop(win_stop), .cap_en(cap_en));

  task automatic check(input string req);
    logic [NUM_CH-1:0] exp;
    exp = rst ? cap_en : (model_open | win_start);
    #1;
    vectors++;
    if (!rst && cap_en !== exp) begin
      errors++;
      $display("FAIL %s: cap_en=%b expected %b", req, cap_en, exp);
    end
  endtask

  // one cycle: drive, check mid-cycle, then edge updates model
  task automatic step(input logic [NUM_CH-1:0] s, input logic [NUM_CH-1:0] p, input string req);
    win_start = s; win_stop = p;
    check(req);
    @(posedge clk);
    if (rst) model_open = '0;
    else model_open = (model_open | s) & ~p;
    #1;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step('0, '0, "R1");
    rst = 1'b0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: expired, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; win_start = '0; win_stop = '0; model_open = '0;
    @(negedge clk);
    do_reset();
    // R1: idle after reset
    step('0, '0, "R1");
    if (cap_en !== '0) begin errors++; $display("FAIL R1: cap_en=%b expected 0", cap_en); end
    vectors++;

    // Exhaustive sequences per channel, from closed and open starting states
    for (int ch = 0; ch < NUM_CH; ch++) begin
      for (int init = 0; init < 2; init++) begin
        for (int seq = 0; seq < 64; seq++) begin
          do_reset();
          if (init == 1) step(NUM_CH'(1) << ch, '0, "R2");
          for (int k = 0; k < 3; k++) begin
            int c;
            c = (seq >> (2*k)) & 3;
            // R3 R4 R5 R6 R7
            step(c[0] ? NUM_CH'(1) << ch : '0, c[1] ? NUM_CH'(1) << ch : '0, "R5");
          end
          step('0, '0, "R3");
        end
      end
    end

    // Directed corners on channel 0
    do_reset();
    step(7'h01, 7'h01, "R5");
    step(7'h00, 7'h00, "R5");
    if (cap_en[0] !== 1'b0) begin errors++; $display("FAIL R5: cap_en0=%b expected 0", cap_en[0]); end
    vectors++;
    step(7'h01, 7'h00, "R2");
    step(7'h00, 7'h01, "R3");
    step(7'h01, 7'h00, "R4");
    if (cap_en[0] !== 1'b1) begin errors++; $display("FAIL R4: cap_en0=%b expected 1", cap_en[0]); end
    vectors++;
    step(7'h01, 7'h01, "R6");
    step(7'h00, 7'h00, "R6");
    step(7'h00, 7'h02, "R7");

    // Random multi-channel run (R8), with reset mid-window (R1)
    for (int n = 0; n < 4000; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      if (n % 997 == 500) do_reset();
      else step(lfsr[6:0] & lfsr[13:7], lfsr[20:14] & lfsr[27:21], "R8");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule